// File: doc/BRIEF.md
# Frame-Indexed Page Match Unit

This block translates an effective page number into a physical word address for a small paged main store. It holds one register per physical page frame. Each register records which effective page currently occupies that frame, a valid flag and a few status bits. A lookup compares the requested page number against every frame register in the same cycle. The index of the matching frame becomes the upper bits of the physical word address, and the word offset passes through unchanged below it. When no frame holds the page, the block raises a fault, and fault-handling software then brings the page in.

Software loads a frame register through a single write port, which sets the page number, status and valid flag of the chosen frame. The block also tracks which frames have been touched since usage was last cleared. From that it offers two placement hints. The first is the lowest frame that holds no valid page. The second is a replacement candidate, used when every frame is occupied and one must be evicted.

Top module: `frame_map_cam`

## Requirements
- R1: After synchronous reset, rsp_valid, rsp_hit, rsp_fault and rsp_multi are 0, free_avail is 1, free_frame is 0 and victim_frame is 0.
- R2: A lookup (lk_valid=1) of a page held in a valid frame F gives, on the clock after it is sampled, rsp_valid=1, rsp_hit=1, rsp_fault=0 and rsp_addr = {F, lk_offset}, where F is the upper IDX_W bits and the offset is the lower 9 bits.
- R3: A lookup that matches no valid frame gives rsp_valid=1, rsp_hit=0, rsp_fault=1 and rsp_addr=0. A frame whose valid flag is 0 never matches, even when its stored page number equals the request.
- R4: When rsp_valid is 1, exactly one of rsp_hit and rsp_fault is 1. When rsp_valid is 0, both are 0.
- R5: wr_en=1 loads wr_epn, wr_stat and wr_valid into frame wr_frame at the clock edge. A lookup sampled at that same edge still sees the old contents. Lookups sampled later see the new contents.
- R6: On a hit, rsp_stat carries the status bits stored in the matching frame.
- R7: free_avail and free_frame report the lowest-numbered frame whose valid flag is 0. They change on the same edge as the write that changes a valid flag. free_avail is 0 when all frames are valid.
- R8: A hit sets the usage bit of the matching frame, and a write clears the usage bit of the written frame. victim_frame is the lowest-numbered frame whose usage bit is clear, and it is updated on the same edge as the usage bits.
- R9: If a hit would leave every usage bit set, all usage bits are cleared instead, so victim_frame becomes 0.
- R10: If more than one valid frame matches, the lowest-numbered one is used for rsp_addr, rsp_stat and usage, and rsp_multi=1 is returned with the response. Otherwise rsp_multi is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_epn | input | EPN_W (8) | Effective page number to translate |
| lk_offset | input | OFF_W (9) | Word offset within the page |
| wr_en | input | 1 | Frame register write strobe |
| wr_frame | input | IDX_W (5) | Frame register to load |
| wr_epn | input | EPN_W (8) | Page number to store |
| wr_stat | input | STAT_W (2) | Status bits to store |
| wr_valid | input | 1 | Valid flag to store |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Page found in a frame |
| rsp_fault | output | 1 | Page not resident |
| rsp_multi | output | 1 | More than one frame matched |
| rsp_addr | output | IDX_W+OFF_W (14) | Physical word address |
| rsp_stat | output | STAT_W (2) | Status bits of the matching frame |
| free_avail | output | 1 | At least one frame is unoccupied |
| free_frame | output | IDX_W (5) | Lowest unoccupied frame |
| victim_frame | output | IDX_W (5) | Suggested replacement frame |

## Verification
Translation is tried with pages resident in low, middle and high frames and with different offsets, so a wrong frame index or a swapped offset shows up in the address. Lookups of pages that are absent, and of pages whose frame has been invalidated while still holding the same number, separate a true miss from a stale-tag match. A write and a lookup to the same page in the same cycle shows whether the lookup sees the old contents or the new ones. The usage hints are followed through a full sweep that hits every frame in order, which exposes a missed wrap-around clear. A deliberate duplicate page number checks the tie-break and the error flag.

// File: rtl/fmap_pkg.sv
package fmap_pkg;

  // Registered outcome of one lookup
  typedef enum logic [1:0] {
    FM_IDLE  = 2'd0,
    FM_HIT   = 2'd1,
    FM_FAULT = 2'd2
  } fm_outcome_e;

endpackage

// File: rtl/fmap_prio.sv
// Lowest-index-first encoder over a request vector.
module fmap_prio #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/fmap_match.sv
// Parallel compare of one page number against every frame tag.
module fmap_match #(
  parameter int N     = 32,
  parameter int EPN_W = 8,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0][EPN_W-1:0] tags,
  input  logic [N-1:0]            valid,
  input  logic [EPN_W-1:0]        key,
  output logic                    any,
  output logic [IDX_W-1:0]        idx,
  output logic                    multi
);

  logic [N-1:0] hits;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = valid[g] && (tags[g] == key);
  end

  fmap_prio #(.N(N), .IDX_W(IDX_W)) u_pick (
    .req (hits),
    .any (any),
    .idx (idx)
  );

  assign multi = ($countones(hits) > 1);

endmodule

// File: rtl/fmap_track.sv
// Valid flags, usage bits and the two placement hints.
module fmap_track #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  output logic [N-1:0]     valid_q,
  output logic             free_any_q,
  output logic [IDX_W-1:0] free_idx_q,
  output logic [IDX_W-1:0] victim_q
);

  logic [N-1:0]     use_q;
  logic [N-1:0]     wr_mask, hit_mask;
  logic [N-1:0]     valid_n, use_set, use_n;
  logic             free_any_n, victim_any_n;
  logic [IDX_W-1:0] free_idx_n, victim_idx_n;

  always_comb begin
    wr_mask  = wr_en  ? (N'(1) << wr_idx)  : '0;
    hit_mask = hit_en ? (N'(1) << hit_idx) : '0;
    valid_n  = wr_valid ? (valid_q | wr_mask) : (valid_q & ~wr_mask);
    use_set  = (use_q | hit_mask) & ~wr_mask;
    use_n    = (&use_set) ? '0 : use_set;
  end

  fmap_prio #(.N(N), .IDX_W(IDX_W)) u_free (
    .req (~valid_n),
    .any (free_any_n),
    .idx (free_idx_n)
  );

  fmap_prio #(.N(N), .IDX_W(IDX_W)) u_victim (
    .req (~use_n),
    .any (victim_any_n),
    .idx (victim_idx_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= '0;
      use_q      <= '0;
      free_any_q <= 1'b1;
      free_idx_q <= '0;
      victim_q   <= '0;
    end else begin
      valid_q    <= valid_n;
      use_q      <= use_n;
      free_any_q <= free_any_n;
      free_idx_q <= free_idx_n;
      victim_q   <= victim_any_n ? victim_idx_n : '0;
    end
  end

  // R7: reported free frame really is unoccupied; no free frame means all valid
  p_free_slot_r7: assert property (@(posedge clk) disable iff (rst)
    free_any_q |-> !valid_q[free_idx_q]);
  p_full_set_r7: assert property (@(posedge clk) disable iff (rst)
    !free_any_q |-> (&valid_q));
  // R8: suggested victim has its usage bit clear
  p_victim_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !use_q[victim_q]);
  // R9: usage bits are never all set at once
  p_use_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    !(&use_q));

endmodule

// File: rtl/frame_map_cam.sv
module frame_map_cam #(
  parameter int FRAMES = 32,
  parameter int EPN_W  = 8,
  parameter int OFF_W  = 9,
  parameter int STAT_W = 2,
  localparam int IDX_W  = $clog2(FRAMES),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [EPN_W-1:0]  lk_epn,
  input  logic [OFF_W-1:0]  lk_offset,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_frame,
  input  logic [EPN_W-1:0]  wr_epn,
  input  logic [STAT_W-1:0] wr_stat,
  input  logic              wr_valid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic              rsp_multi,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [STAT_W-1:0] rsp_stat,
  output logic              free_avail,
  output logic [IDX_W-1:0]  free_frame,
  output logic [IDX_W-1:0]  victim_frame
);
  import fmap_pkg::*;

  logic [FRAMES-1:0][EPN_W-1:0]  tag_mem;
  logic [FRAMES-1:0][STAT_W-1:0] stat_mem;
  logic [FRAMES-1:0]             valid_q;

  logic             m_any, m_multi;
  logic [IDX_W-1:0] m_idx;
  logic             hit_en;
  fm_outcome_e      out_n, out_q;

  // Frame tag and status storage (no reset; valid flags live in the tracker)
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_frame]  <= wr_epn;
      stat_mem[wr_frame] <= wr_stat;
    end
  end

  fmap_match #(.N(FRAMES), .EPN_W(EPN_W), .IDX_W(IDX_W)) u_match (
    .tags  (tag_mem),
    .valid (valid_q),
    .key   (lk_epn),
    .any   (m_any),
    .idx   (m_idx),
    .multi (m_multi)
  );

  assign hit_en = lk_valid && m_any;

  fmap_track #(.N(FRAMES), .IDX_W(IDX_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_frame),
    .wr_valid   (wr_valid),
    .hit_en     (hit_en),
    .hit_idx    (m_idx),
    .valid_q    (valid_q),
    .free_any_q (free_avail),
    .free_idx_q (free_frame),
    .victim_q   (victim_frame)
  );

  always_comb begin
    if (!lk_valid)  out_n = FM_IDLE;
    else if (m_any) out_n = FM_HIT;
    else            out_n = FM_FAULT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= FM_IDLE;
      rsp_valid <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_addr  <= '0;
      rsp_stat  <= '0;
    end else begin
      out_q     <= out_n;
      rsp_valid <= lk_valid;
      rsp_multi <= hit_en && m_multi;
      rsp_addr  <= hit_en ? {m_idx, lk_offset} : '0;
      rsp_stat  <= hit_en ? stat_mem[m_idx] : '0;
    end
  end

  assign rsp_hit   = (out_q == FM_HIT);
  assign rsp_fault = (out_q == FM_FAULT);

  // R4: a present response is either a hit or a fault, never both or neither
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit ^ rsp_fault));
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_fault));
  // R3: a fault carries a zero address
  p_fault_addr_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_addr == '0));
  // R10: the duplicate flag only comes with a hit
  p_multi_hit_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> rsp_hit);

endmodule

// File: tb/frame_map_cam_tb.sv
module frame_map_cam_tb;

  localparam int N = 32;

  logic       clk = 1'b0;
  logic       rst;
  logic       lk_valid;
  logic [7:0] lk_epn;
  logic [8:0] lk_offset;
  logic       wr_en;
  logic [4:0] wr_frame;
  logic [7:0] wr_epn;
  logic [1:0] wr_stat;
  logic       wr_valid;
  logic       rsp_valid, rsp_hit, rsp_fault, rsp_multi;
  logic [13:0] rsp_addr;
  logic [1:0] rsp_stat;
  logic       free_avail;
  logic [4:0] free_frame, victim_frame;

  always #4 clk = ~clk;

  frame_map_cam u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_epn(lk_epn),
    .lk_offset(lk_offset), .wr_en(wr_en), .wr_frame(wr_frame),
    .wr_epn(wr_epn), .wr_stat(wr_stat), .wr_valid(wr_valid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_multi(rsp_multi), .rsp_addr(rsp_addr), .rsp_stat(rsp_stat),
    .free_avail(free_avail), .free_frame(free_frame),
    .victim_frame(victim_frame)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // Reference state built from the requirements
  int         epn_m  [N];
  int         stat_m [N];
  bit [N-1:0] val_m;
  bit [N-1:0] use_m;

  task automatic chk(string tag, string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int lowest_clear(bit [N-1:0] v);
    for (int i = 0; i < N; i++) if (!v[i]) return i;
    return -1;
  endfunction

  task automatic check_hints(string tag);
    int f;
    f = lowest_clear(val_m);
    chk(tag, "free_avail", int'(free_avail), (f >= 0) ? 1 : 0);
    if (f >= 0) chk(tag, "free_frame", int'(free_frame), f);
    chk(tag, "victim_frame", int'(victim_frame), lowest_clear(use_m));
  endtask

  task automatic model_write(int f, int e, int s, bit v);
    epn_m[f]  = e;
    stat_m[f] = s;
    val_m[f]  = v;
    use_m[f]  = 1'b0;
  endtask

  // R5, R7, R8: write one frame register
  task automatic do_write(int f, int e, int s, bit v, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_frame = 5'(f); wr_epn = 8'(e);
    wr_stat = 2'(s); wr_valid = v;
    @(posedge clk);
    #2;
    wr_en = 1'b0;
    model_write(f, e, s, v);
    check_hints(tag);
  endtask

  // R2, R3, R6, R8, R9, R10: one lookup, checked against the model
  task automatic do_lookup(int e, int off, string tag);
    int idx, cnt;
    @(negedge clk);
    lk_valid = 1'b1; lk_epn = 8'(e); lk_offset = 9'(off);
    @(posedge clk);
    #2;
    lk_valid = 1'b0;
    idx = -1; cnt = 0;
    for (int i = 0; i < N; i++) begin
      if (val_m[i] && epn_m[i] == e) begin
        if (idx < 0) idx = i;
        cnt++;
      end
    end
    chk(tag, "rsp_valid", int'(rsp_valid), 1);
    chk(tag, "rsp_hit", int'(rsp_hit), (idx >= 0) ? 1 : 0);
    chk(tag, "rsp_fault", int'(rsp_fault), (idx >= 0) ? 0 : 1);
    chk(tag, "rsp_multi", int'(rsp_multi), (cnt > 1) ? 1 : 0);
    if (idx >= 0) begin
      chk(tag, "rsp_addr", int'(rsp_addr), idx * 512 + off);
      chk(tag, "rsp_stat", int'(rsp_stat), stat_m[idx]);
      use_m[idx] = 1'b1;
      if (&use_m) use_m = '0;
    end else begin
      chk(tag, "rsp_addr", int'(rsp_addr), 0);
    end
    check_hints(tag);
  endtask

  task automatic t_reset();
    rst = 1'b1; lk_valid = 1'b0; lk_epn = '0; lk_offset = '0;
    wr_en = 1'b0; wr_frame = '0; wr_epn = '0; wr_stat = '0; wr_valid = 1'b0;
    val_m = '0; use_m = '0;
    for (int i = 0; i < N; i++) begin epn_m[i] = 0; stat_m[i] = 0; end
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    // R1: reset state
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "rsp_hit", int'(rsp_hit), 0);
    chk("R1", "rsp_fault", int'(rsp_fault), 0);
    chk("R1", "rsp_multi", int'(rsp_multi), 0);
    check_hints("R1");
  endtask

  task automatic t_basic();
    for (int i = 0; i < 4; i++) do_write(i, 10 + i, i, 1'b1, "R7");
    do_lookup(12, 'h1A5, "R2");
    do_lookup(200, 'h033, "R3");
    do_lookup(10, 'h000, "R8");
    do_lookup(11, 'h1FF, "R8");
    do_write(0, 10, 3, 1'b1, "R8");
    do_lookup(13, 'h0F0, "R6");
  endtask

  // R5: lookup in the same cycle as the write sees the old contents
  task automatic t_same_cycle();
    @(negedge clk);
    wr_en = 1'b1; wr_frame = 5'd5; wr_epn = 8'd50; wr_stat = 2'd2; wr_valid = 1'b1;
    lk_valid = 1'b1; lk_epn = 8'd50; lk_offset = 9'd7;
    @(posedge clk);
    #2;
    wr_en = 1'b0; lk_valid = 1'b0;
    chk("R5", "same-cycle rsp_fault", int'(rsp_fault), 1);
    chk("R5", "same-cycle rsp_hit", int'(rsp_hit), 0);
    model_write(5, 50, 2, 1'b1);
    check_hints("R5");
    do_lookup(50, 7, "R5");
  endtask

  // R3, R7: an invalidated frame never matches and becomes free
  task automatic t_invalidate();
    do_write(1, 11, 1, 1'b0, "R7");
    do_lookup(11, 'h010, "R3");
    do_write(1, 11, 1, 1'b1, "R7");
  endtask

  // R7, R9: fill all frames, then hit each in order
  task automatic t_sweep();
    for (int i = 0; i < N; i++) do_write(i, 10 + i, i % 4, 1'b1, "R7");
    chk("R7", "free_avail when full", int'(free_avail), 0);
    for (int i = 0; i < N; i++) do_lookup(10 + i, i * 3, "R9");
    chk("R9", "victim after full sweep", int'(victim_frame), lowest_clear(use_m));
  endtask

  // R10: duplicate page number in two frames
  task automatic t_multi();
    do_write(7, 20, 2, 1'b1, "R10");
    do_lookup(20, 'h155, "R10");
    chk("R10", "winner frame", int'(rsp_addr) / 512, 7);
    do_lookup(30, 'h001, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_same_cycle();
    t_invalidate();
    t_sweep();
    t_multi();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule